// File: doc/BRIEF.md
# Variable-Block SAD Adder Tree with Asymmetric Partitions

This block takes the per-pixel absolute differences between one 32x32 reference candidate and the current block, and in one pass produces the sum of absolute differences (SAD) of every prediction block that an inter-prediction quadtree over that 32x32 area can ask for. The sums cover square and half-splits at the 8x8, 16x16 and 32x32 coding-block levels, plus the asymmetric quarter splits at the 16x16 and 32x32 levels. That makes 145 sums per candidate. No asymmetric split exists at the 8x8 level, and 4x4 sums are kept internal and never emitted.

The 32x32 array is built from four 16x16 execution units, each holding sixteen 4x4 execution units. Every larger sum is formed by adding sums already produced one level down, never by re-adding raw differences. A candidate may be presented every clock cycle. The result vector and its valid flag leave a register after a fixed latency, and that latency is set by parameters. When the coding tree is 64x64, the upstream logic down-samples it by a quarter so that this tree always sees 32x32. The difference generator and the minimum search sit outside the block.

Top module: `sad_amp_tree`

## Requirements
- R1: Input pixel (x,y), 0..31 each, sits at bits [(32*y+x)*DIFF_W +: DIFF_W] of `diff_i`. `sad_o` carries 145 lanes of DIFF_W+10 bits, zero-extended, with lane i at bits [i*(DIFF_W+10) +: DIFF_W+10]. An 8x8 block index k is 4*(y/8)+(x/8). A 16x16 quadrant index q is 2*(y/16)+(x/16).
- R2: Lane 2k+h is the 8x4 half of 8x8 block k, where h=0 is the top 4 rows. Lane 32+2k+h is the 4x8 half, where h=0 is the left 4 columns.
- R3: Lane 64+k is the SAD of 8x8 block k.
- R4: Lane 80+2q+h is the 16x8 half of quadrant q (h=0 top). Lane 88+2q+h is its 8x16 half (h=0 left). Lane 96+q is the whole quadrant.
- R5: Lanes 100 and 101 are the top and bottom 32x16 halves. Lanes 102 and 103 are the left and right 16x32 halves. Lane 104 is the whole 32x32 block.
- R6: Lane 105+8q+2m+p is a quarter split of quadrant q, with part p in 0..1. For m=0, p0 is the top 4 rows and p1 the other 12. For m=1, p0 is the top 12 rows and p1 the bottom 4. For m=2, p0 is the left 4 columns and p1 the other 12. For m=3, p0 is the left 12 columns and p1 the right 4.
- R7: Lane 137+2m+p is the same quarter split, with the same m and p meaning, over the whole 32x32 block, using 8 and 24 rows or columns.
- R8: No sum wraps. With every difference at 2^DIFF_W-1, lane 104 equals 1024*(2^DIFF_W-1), which is 261120 for 8-bit input.
- R9: `valid_o` pulses one cycle, exactly 1+REG_EU4+REG_EU16 clocks after each cycle in which `valid_i` is high (2 by default). Strobes on consecutive cycles give results on consecutive cycles.
- R10: `sad_o` changes only when a result arrives. Changing `diff_i` while `valid_i` is low leaves `sad_o` as it was.
- R11: A synchronous active-high `rst` clears `valid_o` and all lanes of `sad_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Candidate differences present this cycle |
| diff_i | input | 1024*DIFF_W | Absolute differences, row-major |
| valid_o | output | 1 | Result strobe |
| sad_o | output | 145*(DIFF_W+10) | Registered SAD lanes |

## Verification
Each partition shape is tried with several difference patterns. Constant fields test the area of each lane. Horizontal and vertical ramps give rows and columns different weights, so a swapped top/bottom or left/right part would show up. A pseudo-random field and a checkerboard expose a wrong cell being picked up by an adder. Single hot pixels placed in different quadrants, together with a field that is bright only in its top rows, tie each lane index to exactly one rectangle. These last patterns separate the upper split from the lower split and the inner quadrant lanes from the whole-block ones. Directed runs then cover saturated input, holding the output while the input changes without a strobe, back-to-back strobes, and the reset values.

// File: rtl/sad_tree_pkg.sv
package sad_tree_pkg;
  localparam int BLK      = 32;
  localparam int EU_DIM   = 16;
  localparam int CELL_DIM = 4;
  localparam int NUM_EU   = (BLK / EU_DIM) * (BLK / EU_DIM);
  localparam int CELLS_EU = (EU_DIM / CELL_DIM) * (EU_DIM / CELL_DIM);
  localparam int CELL_PIX = CELL_DIM * CELL_DIM;

  // output lane bases
  localparam int B_8X4   = 0;
  localparam int B_4X8   = 32;
  localparam int B_8X8   = 64;
  localparam int B_16X8  = 80;
  localparam int B_8X16  = 88;
  localparam int B_16X16 = 96;
  localparam int B_32X16 = 100;
  localparam int B_16X32 = 102;
  localparam int B_32X32 = 104;
  localparam int B_AMP16 = 105;
  localparam int B_AMP32 = 137;
  localparam int NUM_SAD = 145;

  // lanes leaving one 16x16 execution unit
  localparam int EL_8X4   = 0;
  localparam int EL_4X8   = 8;
  localparam int EL_8X8   = 16;
  localparam int EL_16X8  = 20;
  localparam int EL_8X16  = 22;
  localparam int EL_16X16 = 24;
  localparam int EL_AMP   = 25;
  localparam int EU_LANES = 33;

  typedef enum logic [1:0] {QS_TOP = 2'd0, QS_BOT = 2'd1, QS_LEFT = 2'd2, QS_RIGHT = 2'd3} qsplit_e;
endpackage

// File: rtl/sad_pipe_reg.sv
module sad_pipe_reg #(
  parameter int W      = 8,
  parameter bit EN_REG = 1'b1
) (
  input  logic         clk,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN_REG) begin : g_ff
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (en) r <= d;
      end
      assign q = r;
    end else begin : g_pass
      logic unused_ctl;
      assign unused_ctl = clk ^ en;
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/sad_cell4.sv
module sad_cell4
  import sad_tree_pkg::*;
#(
  parameter int DW = 8,
  localparam int SW = DW + $clog2(CELL_PIX)
) (
  input  logic [CELL_PIX*DW-1:0] diff_i,
  output logic [SW-1:0]          sum_o
);
  logic [SW-1:0] row_s [CELL_DIM];

  // two-level tree: row sums, then the cell
  always_comb begin
    for (int r = 0; r < CELL_DIM; r++) begin
      row_s[r] = '0;
      for (int c = 0; c < CELL_DIM; c++)
        row_s[r] = row_s[r] + SW'(diff_i[(r*CELL_DIM+c)*DW +: DW]);
    end
    sum_o = '0;
    for (int r = 0; r < CELL_DIM; r++) sum_o = sum_o + row_s[r];
  end
endmodule

// File: rtl/sad_eu16.sv
module sad_eu16
  import sad_tree_pkg::*;
#(
  parameter int DW       = 8,
  parameter bit REG_CELL = 1'b1,
  localparam int W4  = DW + 4,
  localparam int W16 = DW + 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cell_en,
  input  logic                     chk_vld,
  input  logic [EU_DIM*EU_DIM*DW-1:0] diff_i,
  output logic [EU_LANES*W16-1:0]  lanes_o
);
  localparam int CG = EU_DIM / CELL_DIM;

  logic [CELLS_EU*W4-1:0] cell_raw, cell_q;

  generate
    for (genvar c = 0; c < CELLS_EU; c++) begin : g_cell
      logic [CELL_PIX*DW-1:0] px;
      for (genvar ly = 0; ly < CELL_DIM; ly++) begin : g_row
        for (genvar lx = 0; lx < CELL_DIM; lx++) begin : g_col
          assign px[(ly*CELL_DIM+lx)*DW +: DW] =
            diff_i[(((c/CG)*CELL_DIM+ly)*EU_DIM + (c%CG)*CELL_DIM + lx)*DW +: DW];
        end
      end
      sad_cell4 #(.DW(DW)) u_cell (.diff_i(px), .sum_o(cell_raw[c*W4 +: W4]));
    end
  endgenerate

  sad_pipe_reg #(.W(CELLS_EU*W4), .EN_REG(REG_CELL)) u_cell_reg (
    .clk(clk), .en(cell_en), .d(cell_raw), .q(cell_q)
  );

  logic [W16-1:0] cs   [CG][CG];
  logic [W16-1:0] s84  [8];
  logic [W16-1:0] s48  [8];
  logic [W16-1:0] s88  [4];
  logic [W16-1:0] s168 [2];
  logic [W16-1:0] s816 [2];
  logic [W16-1:0] s16;
  logic [W16-1:0] rstrip [CG];
  logic [W16-1:0] cstrip [CG];
  logic [W16-1:0] amp  [8];

  always_comb begin
    for (int r = 0; r < CG; r++)
      for (int k = 0; k < CG; k++)
        cs[r][k] = W16'(cell_q[(r*CG+k)*W4 +: W4]);

    for (int br = 0; br < 2; br++)
      for (int bc = 0; bc < 2; bc++)
        for (int h = 0; h < 2; h++) begin
          s84[2*(br*2+bc)+h] = cs[2*br+h][2*bc] + cs[2*br+h][2*bc+1];
          s48[2*(br*2+bc)+h] = cs[2*br][2*bc+h] + cs[2*br+1][2*bc+h];
        end
    for (int kb = 0; kb < 4; kb++) s88[kb] = s84[2*kb] + s84[2*kb+1];
    for (int h = 0; h < 2; h++) begin
      s168[h] = s88[2*h] + s88[2*h+1];
      s816[h] = s88[h] + s88[h+2];
    end
    s16 = s168[0] + s168[1];

    for (int i = 0; i < CG; i++) begin
      rstrip[i] = cs[i][0] + cs[i][1] + cs[i][2] + cs[i][3];
      cstrip[i] = cs[0][i] + cs[1][i] + cs[2][i] + cs[3][i];
    end
    amp[2*QS_TOP]     = rstrip[0];
    amp[2*QS_TOP+1]   = rstrip[1] + rstrip[2] + rstrip[3];
    amp[2*QS_BOT]     = rstrip[0] + rstrip[1] + rstrip[2];
    amp[2*QS_BOT+1]   = rstrip[3];
    amp[2*QS_LEFT]    = cstrip[0];
    amp[2*QS_LEFT+1]  = cstrip[1] + cstrip[2] + cstrip[3];
    amp[2*QS_RIGHT]   = cstrip[0] + cstrip[1] + cstrip[2];
    amp[2*QS_RIGHT+1] = cstrip[3];

    lanes_o = '0;
    for (int i = 0; i < 8; i++) begin
      lanes_o[(EL_8X4+i)*W16 +: W16] = s84[i];
      lanes_o[(EL_4X8+i)*W16 +: W16] = s48[i];
      lanes_o[(EL_AMP+i)*W16 +: W16] = amp[i];
    end
    for (int i = 0; i < 4; i++) lanes_o[(EL_8X8+i)*W16 +: W16] = s88[i];
    for (int i = 0; i < 2; i++) begin
      lanes_o[(EL_16X8+i)*W16 +: W16]  = s168[i];
      lanes_o[(EL_8X16+i)*W16 +: W16] = s816[i];
    end
    lanes_o[EL_16X16*W16 +: W16] = s16;
  end

  // R4: quadrant built from horizontal halves must match vertical halves
  assert_eu_halves_R4: assert property (@(posedge clk) disable iff (rst)
    chk_vld |-> (s16 == s816[0] + s816[1]));

  // R6: each asymmetric pair must cover the whole quadrant
  assert_eu_quarters_R6: assert property (@(posedge clk) disable iff (rst)
    chk_vld |-> ((amp[0] + amp[1] == s16) && (amp[2] + amp[3] == s16) &&
                 (amp[4] + amp[5] == s16) && (amp[6] + amp[7] == s16)));
endmodule

// File: rtl/sad_amp_tree.sv
module sad_amp_tree
  import sad_tree_pkg::*;
#(
  parameter int DIFF_W   = 8,
  parameter bit REG_EU4  = 1'b1,
  parameter bit REG_EU16 = 1'b0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              valid_i,
  input  logic [BLK*BLK*DIFF_W-1:0]         diff_i,
  output logic                              valid_o,
  output logic [NUM_SAD*(DIFF_W+10)-1:0]    sad_o
);
  localparam int W16   = DIFF_W + 8;
  localparam int SAD_W = DIFF_W + 10;
  localparam int EUW   = EU_LANES * W16;
  localparam int LAT   = 1 + int'(REG_EU4) + int'(REG_EU16);
  localparam logic [2:0] LAT3 = 3'(LAT);
  localparam logic [SAD_W-1:0] MAX_FULL = SAD_W'((BLK*BLK) * ((1 << DIFF_W) - 1));

  // ---------------- valid pipeline ----------------
  logic v_cell, v_eu;
  generate
    if (REG_EU4) begin : g_vc
      logic r;
      always_ff @(posedge clk) r <= rst ? 1'b0 : valid_i;
      assign v_cell = r;
    end else begin : g_vc_pass
      assign v_cell = valid_i;
    end
    if (REG_EU16) begin : g_ve
      logic r;
      always_ff @(posedge clk) r <= rst ? 1'b0 : v_cell;
      assign v_eu = r;
    end else begin : g_ve_pass
      assign v_eu = v_cell;
    end
  endgenerate

  // ---------------- 16x16 execution units ----------------
  logic [EUW-1:0] eu_raw [NUM_EU];
  logic [EUW-1:0] eu_q   [NUM_EU];
  logic [W16-1:0] el     [NUM_EU][EU_LANES];

  generate
    for (genvar q = 0; q < NUM_EU; q++) begin : g_eu
      logic [EU_DIM*EU_DIM*DIFF_W-1:0] qpx;
      for (genvar ly = 0; ly < EU_DIM; ly++) begin : g_y
        for (genvar lx = 0; lx < EU_DIM; lx++) begin : g_x
          assign qpx[(ly*EU_DIM+lx)*DIFF_W +: DIFF_W] =
            diff_i[(((q/2)*EU_DIM+ly)*BLK + (q%2)*EU_DIM + lx)*DIFF_W +: DIFF_W];
        end
      end
      sad_eu16 #(.DW(DIFF_W), .REG_CELL(REG_EU4)) u_eu (
        .clk(clk), .rst(rst), .cell_en(valid_i), .chk_vld(v_cell),
        .diff_i(qpx), .lanes_o(eu_raw[q])
      );
      sad_pipe_reg #(.W(EUW), .EN_REG(REG_EU16)) u_eu_reg (
        .clk(clk), .en(v_cell), .d(eu_raw[q]), .q(eu_q[q])
      );
      for (genvar i = 0; i < EU_LANES; i++) begin : g_lane
        assign el[q][i] = eu_q[q][i*W16 +: W16];
      end
    end
  endgenerate

  // ---------------- 32x32 level and lane assembly ----------------
  logic [SAD_W-1:0] q16  [NUM_EU];
  logic [SAD_W-1:0] q168 [NUM_EU][2];
  logic [SAD_W-1:0] q816 [NUM_EU][2];
  logic [SAD_W-1:0] r8   [4];
  logic [SAD_W-1:0] c8   [4];
  logic [SAD_W-1:0] s3216 [2];
  logic [SAD_W-1:0] s1632 [2];
  logic [SAD_W-1:0] full;
  logic [SAD_W-1:0] a32  [8];
  logic [NUM_SAD*SAD_W-1:0] nxt;

  always_comb begin
    for (int q = 0; q < NUM_EU; q++) begin
      q16[q] = SAD_W'(el[q][EL_16X16]);
      for (int h = 0; h < 2; h++) begin
        q168[q][h] = SAD_W'(el[q][EL_16X8+h]);
        q816[q][h] = SAD_W'(el[q][EL_8X16+h]);
      end
    end
    for (int h = 0; h < 2; h++) begin
      s3216[h] = q16[2*h] + q16[2*h+1];
      s1632[h] = q16[h] + q16[h+2];
    end
    full = q16[0] + q16[1] + q16[2] + q16[3];
    for (int s = 0; s < 4; s++) begin
      r8[s] = q168[2*(s/2)][s%2] + q168[2*(s/2)+1][s%2];
      c8[s] = q816[s/2][s%2] + q816[s/2+2][s%2];
    end
    a32[2*QS_TOP]     = r8[0];
    a32[2*QS_TOP+1]   = r8[1] + r8[2] + r8[3];
    a32[2*QS_BOT]     = r8[0] + r8[1] + r8[2];
    a32[2*QS_BOT+1]   = r8[3];
    a32[2*QS_LEFT]    = c8[0];
    a32[2*QS_LEFT+1]  = c8[1] + c8[2] + c8[3];
    a32[2*QS_RIGHT]   = c8[0] + c8[1] + c8[2];
    a32[2*QS_RIGHT+1] = c8[3];

    nxt = '0;
    for (int q = 0; q < NUM_EU; q++) begin
      for (int br = 0; br < 2; br++)
        for (int bc = 0; bc < 2; bc++) begin
          nxt[(B_8X8 + ((q/2)*2+br)*4 + (q%2)*2+bc)*SAD_W +: SAD_W] =
            SAD_W'(el[q][EL_8X8 + br*2+bc]);
          for (int h = 0; h < 2; h++) begin
            nxt[(B_8X4 + 2*(((q/2)*2+br)*4 + (q%2)*2+bc) + h)*SAD_W +: SAD_W] =
              SAD_W'(el[q][EL_8X4 + 2*(br*2+bc) + h]);
            nxt[(B_4X8 + 2*(((q/2)*2+br)*4 + (q%2)*2+bc) + h)*SAD_W +: SAD_W] =
              SAD_W'(el[q][EL_4X8 + 2*(br*2+bc) + h]);
          end
        end
      for (int h = 0; h < 2; h++) begin
        nxt[(B_16X8 + 2*q + h)*SAD_W +: SAD_W] = q168[q][h];
        nxt[(B_8X16 + 2*q + h)*SAD_W +: SAD_W] = q816[q][h];
      end
      nxt[(B_16X16 + q)*SAD_W +: SAD_W] = q16[q];
      for (int j = 0; j < 8; j++)
        nxt[(B_AMP16 + 8*q + j)*SAD_W +: SAD_W] = SAD_W'(el[q][EL_AMP + j]);
    end
    for (int h = 0; h < 2; h++) begin
      nxt[(B_32X16 + h)*SAD_W +: SAD_W] = s3216[h];
      nxt[(B_16X32 + h)*SAD_W +: SAD_W] = s1632[h];
    end
    nxt[B_32X32*SAD_W +: SAD_W] = full;
    for (int j = 0; j < 8; j++) nxt[(B_AMP32 + j)*SAD_W +: SAD_W] = a32[j];
  end

  // ---------------- output register ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      sad_o   <= '0;
    end else begin
      valid_o <= v_eu;
      if (v_eu) sad_o <= nxt;
    end
  end

  // ---------------- checks ----------------
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != LAT3) since_rst <= since_rst + 3'd1;
  end

  logic [SAD_W-1:0] o_full, o_h0, o_h1, o_up0, o_up1, o_lf0, o_lf1;
  assign o_full = sad_o[B_32X32*SAD_W +: SAD_W];
  assign o_h0   = sad_o[B_32X16*SAD_W +: SAD_W];
  assign o_h1   = sad_o[(B_32X16+1)*SAD_W +: SAD_W];
  assign o_up0  = sad_o[(B_AMP32+2*QS_TOP)*SAD_W +: SAD_W];
  assign o_up1  = sad_o[(B_AMP32+2*QS_TOP+1)*SAD_W +: SAD_W];
  assign o_lf0  = sad_o[(B_AMP32+2*QS_LEFT)*SAD_W +: SAD_W];
  assign o_lf1  = sad_o[(B_AMP32+2*QS_LEFT+1)*SAD_W +: SAD_W];

  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (rst)
    (since_rst == LAT3) |-> (valid_o == $past(valid_i, LAT)));

  assert_full_halves_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (o_full == o_h0 + o_h1));

  assert_amp32_cover_R7: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((o_up0 + o_up1 == o_full) && (o_lf0 + o_lf1 == o_full)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (o_full <= MAX_FULL));
endmodule

// File: tb/sad_amp_tree_bench.sv
module sad_amp_tree_bench;
  localparam int DW    = 8;
  localparam bit RE4   = 1'b1;
  localparam bit RE16  = 1'b0;
  localparam int LAT   = 1 + int'(RE4) + int'(RE16);
  localparam int SAD_W = DW + 10;
  localparam int NS    = 145;
  localparam int NPIX  = 1024;

  // {kind[3:0], param[11:0]}
  localparam logic [15:0] VEC_TBL [11] = '{
    {4'd0, 12'd0},   {4'd0, 12'd255}, {4'd1, 12'd3},   {4'd2, 12'd5},
    {4'd3, 12'd1},   {4'd3, 12'd77},  {4'd4, 12'd200}, {4'd5, 12'd0},
    {4'd5, 12'd1023},{4'd5, 12'd531}, {4'd6, 12'd12}
  };

  logic clk = 1'b0;
  logic rst;
  logic valid_i;
  logic [NPIX*DW-1:0] diff_i;
  logic valid_o;
  logic [NS*SAD_W-1:0] sad_o;

  always #5 clk = ~clk;

  sad_amp_tree #(.DIFF_W(DW), .REG_EU4(RE4), .REG_EU16(RE16)) u_sad_amp_tree (
    .clk(clk), .rst(rst), .valid_i(valid_i), .diff_i(diff_i),
    .valid_o(valid_o), .sad_o(sad_o)
  );

  int checks = 0;
  int fails  = 0;
  int pm [32][32];
  logic [NPIX*DW-1:0] stim;
  longint exp_a [NS];
  longint exp_b [NS];

  function automatic int pix_val(int kind, int prm, int x, int y);
    case (kind)
      0: return prm & 255;
      1: return (x*prm + y) & 255;
      2: return (y*prm + 3*x) & 255;
      3: return ((x*37 + y*101 + prm*13) ^ (x*y)) & 255;
      4: return ((x ^ y) & 1) != 0 ? (prm & 255) : 0;
      5: return (y*32 + x == prm) ? 255 : 0;
      default: return (y < prm) ? 255 : 1;
    endcase
  endfunction

  task automatic load(input int kind, input int prm);
    for (int y = 0; y < 32; y++)
      for (int x = 0; x < 32; x++) begin
        pm[y][x] = pix_val(kind, prm, x, y);
        stim[(y*32+x)*DW +: DW] = DW'(pm[y][x]);
      end
  endtask

  // rectangle of each lane, written from R2 to R7
  function automatic void get_rect(input int idx, output int x0, output int y0,
                                   output int w, output int h);
    int j, k, q, m, p, qx, qy;
    if (idx < 64) begin
      j = idx % 32; k = j / 2; p = j % 2;
      x0 = (k % 4) * 8; y0 = (k / 4) * 8;
      if (idx < 32) begin y0 = y0 + 4*p; w = 8; h = 4; end
      else begin x0 = x0 + 4*p; w = 4; h = 8; end
    end else if (idx < 80) begin
      k = idx - 64; x0 = (k % 4) * 8; y0 = (k / 4) * 8; w = 8; h = 8;
    end else if (idx < 100) begin
      if (idx < 96) begin j = (idx - 80) % 8; q = j / 2; p = j % 2; end
      else begin q = idx - 96; p = 0; end
      x0 = (q % 2) * 16; y0 = (q / 2) * 16;
      if (idx < 88) begin y0 = y0 + 8*p; w = 16; h = 8; end
      else if (idx < 96) begin x0 = x0 + 8*p; w = 8; h = 16; end
      else begin w = 16; h = 16; end
    end else if (idx < 105) begin
      x0 = 0; y0 = 0; w = 32; h = 32;
      if (idx < 102) begin y0 = 16*(idx-100); h = 16; end
      else if (idx < 104) begin x0 = 16*(idx-102); w = 16; end
    end else begin
      int s, a;
      if (idx < 137) begin
        j = idx - 105; q = j / 8; qx = (q % 2) * 16; qy = (q / 2) * 16; s = 16;
        m = (j / 2) % 4; p = j % 2;
      end else begin
        j = idx - 137; qx = 0; qy = 0; s = 32; m = j / 2; p = j % 2;
      end
      a = s / 4;
      x0 = qx; y0 = qy; w = s; h = s;
      case (m)
        0: if (p == 0) h = a; else begin y0 = qy + a; h = s - a; end
        1: if (p == 0) h = s - a; else begin y0 = qy + s - a; h = a; end
        2: if (p == 0) w = a; else begin x0 = qx + a; w = s - a; end
        default: if (p == 0) w = s - a; else begin x0 = qx + s - a; w = a; end
      endcase
    end
  endfunction

  function automatic longint expected(int idx);
    int x0, y0, w, h;
    longint acc = 0;
    get_rect(idx, x0, y0, w, h);
    for (int y = y0; y < y0 + h; y++)
      for (int x = x0; x < x0 + w; x++) acc += pm[y][x];
    return acc;
  endfunction

  function automatic string req_of(int idx);
    if (idx < 64) return "R2";
    if (idx < 80) return "R3";
    if (idx < 100) return "R4";
    if (idx < 105) return "R5";
    if (idx < 137) return "R6";
    return "R7";
  endfunction

  function automatic longint lane(int i);
    return longint'(sad_o[i*SAD_W +: SAD_W]);
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic check_lanes(input string tag, input longint e [NS]);
    for (int i = 0; i < NS; i++)
      check(req_of(i), $sformatf("%s lane %0d", tag, i), lane(i), e[i]);
  endtask

  task automatic fill_exp(output longint e [NS]);
    for (int i = 0; i < NS; i++) e[i] = expected(i);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; diff_i = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "valid_o in reset", longint'(valid_o), 0);
    for (int i = 0; i < NS; i++) check("R11", $sformatf("reset lane %0d", i), lane(i), 0);
    rst = 1'b0;
    @(negedge clk);

    // table walk: main function under distinct patterns
    for (int v = 0; v < 11; v++) begin
      load(int'(VEC_TBL[v][15:12]), int'(VEC_TBL[v][11:0]));
      fill_exp(exp_a);
      diff_i = stim; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      if (LAT > 1) check("R9", "valid_o before latency", longint'(valid_o), 0);
      repeat (LAT - 1) @(negedge clk);
      check("R9", "valid_o at latency", longint'(valid_o), 1);
      check_lanes($sformatf("vec%0d", v), exp_a);
      @(negedge clk);
      check("R9", "valid_o single pulse", longint'(valid_o), 0);
    end

    // R1: single hot pixel at (5,0) lands in the left-top lanes only
    load(5, 5);
    diff_i = stim; valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    check("R1", "hot (5,0) 8x4 lane 0", lane(0), 255);
    check("R1", "hot (5,0) 4x8 lane 33", lane(33), 255);
    check("R1", "hot (5,0) 4x8 lane 32", lane(32), 0);
    check("R1", "hot (5,0) 8x4 lane 1", lane(1), 0);

    // R8: saturated input
    load(0, 255);
    fill_exp(exp_a);
    diff_i = stim; valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    check("R8", "full block saturated", lane(104), 261120);
    check("R8", "quadrant saturated", lane(96), 65280);
    check("R8", "32x24 saturated", lane(138), 195840);

    // R10: input changes without strobe have no effect
    load(3, 9);
    diff_i = stim;
    repeat (5) @(negedge clk);
    check("R10", "valid_o idle", longint'(valid_o), 0);
    check_lanes("R10 hold", exp_a);

    // R9: back-to-back strobes
    load(2, 7); fill_exp(exp_b);
    begin
      logic [NPIX*DW-1:0] stim_b;
      stim_b = stim;
      load(1, 11); fill_exp(exp_a);
      diff_i = stim; valid_i = 1'b1;
      for (int cyc = 0; cyc < LAT + 2; cyc++) begin
        @(negedge clk);
        if (cyc == LAT - 1) begin
          check("R9", "b2b first valid", longint'(valid_o), 1);
          check_lanes("R9 b2b first", exp_a);
        end
        if (cyc == LAT) begin
          check("R9", "b2b second valid", longint'(valid_o), 1);
          check_lanes("R9 b2b second", exp_b);
        end
        if (cyc == LAT + 1) check("R9", "b2b end", longint'(valid_o), 0);
        if (cyc == 0) diff_i = stim_b;
        if (cyc == 1) valid_i = 1'b0;
      end
    end

    // R11: reset after activity clears outputs
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11", "valid_o after reset", longint'(valid_o), 0);
    check("R11", "full lane after reset", lane(104), 0);
    check("R11", "first lane after reset", lane(0), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule